// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two counting channels. Each channel is a high byte and a low byte, and each counts either internal machine-cycle strobes or falling edges seen on its own external pin. One 8-bit mode register sets up both channels; channel 0 uses its lower four bits and channel 1 its upper four. Each channel can run as a 13-bit counter with a 5-bit prescaler, a full 16-bit counter, or an 8-bit counter that reloads itself from the high byte. Channel 0 has a fourth setting that splits it into two independent 8-bit counters.

A control register holds a run bit and a sticky overflow flag per channel. A gate bit can make a channel count only while its external gate pin is high. Software reaches the count bytes and both registers through a simple write port and a registered read port. A per-channel acknowledge input clears a flag from outside. Channel 1 also drives a one-cycle overflow pulse that a rate generator elsewhere can use.

Top module: `dual_tmr`

## Requirements
- R1: After a synchronous reset, all six registers read 0, `ovf_flag` is 0 and `ch1_pulse` is 0.
- R2: The register addresses are 0 mode, 1 control, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high. A write lands at the clock edge. `rd_data` shows the addressed register one clock after `rd_addr` is applied. Mode bits per channel nibble, from MSB to LSB, are gate, source (1 = external pin), mode[1:0]. Control bits are 0 run0, 1 run1, 2 flag0, 3 flag1.
- R3: Mode 00 (13-bit): each step increments low[4:0]. When low[4:0] wraps from 31 to 0, the high byte increments. Low[7:5] is not changed. Wrapping from high = 0xFF and low[4:0] = 31 sets the channel flag.
- R4: Mode 01 (16-bit): each step increments {high,low}. The step from 0xFFFF wraps to 0x0000 and sets the flag.
- R5: Mode 10 (reload): each step increments the low byte. A step at low = 0xFF loads low from high, sets the flag, and leaves high unchanged.
- R6: Channel 0 mode 11 (split): the low byte is an 8-bit counter that uses channel 0's run, gate, source and flag0. The high byte is an 8-bit counter that counts machine cycles while run1 is set, and it sets flag1 when it wraps. Channel 1 then counts on every step of its source, whatever run1 and gate1 are, and its overflows do not set flag1.
- R7: Channel 1 set to mode 11 holds its count.
- R8: With the gate bit set, a channel counts only while run is 1 and its gate pin is 1. With the gate bit clear, only run matters.
- R9: A timer step is a `cyc_en` strobe. A counter step is taken on a `cyc_en` strobe when the pin sampled at the previous strobe was 1 and is now 0. Two steps never occur on adjacent clocks.
- R10: A write to the control register loads the flags. An `ack` bit clears its flag. A hardware overflow in the same cycle wins over both.
- R11: A write to a count byte replaces that byte and cancels that channel's step in that cycle (in split mode, only that half's step).
- R12: `ch1_pulse` is high for exactly one clock, one clock after each channel 1 counter overflow, including in split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle strobe |
| gate_pin | input | 2 | Per-channel external gate pins |
| cnt_pin | input | 2 | Per-channel external count pins |
| ack | input | 2 | Per-channel flag clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Registered read data |
| ovf_flag | output | 2 | Overflow flags |
| ch1_pulse | output | 1 | Channel 1 overflow pulse |

## Verification
Each mode is started from two kinds of preload. One kind sits just below a wrap boundary and one sits in the middle of the range. Comparing the two shows whether carry, reload and flag setting happen only at the boundary. Mode 00 starts with the upper low-byte bits set, which shows whether those bits are truly left alone. Gate-low against gate-high runs, and pin patterns that mix real falling edges, flat lows and toggles between strobes, show which inputs actually produce a step. Split-mode runs look at where overflows land: on flag1, in the pulse, or not at all.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CNT13   = 2'b00,
    CNT16   = 2'b01,
    RELOAD8 = 2'b10,
    SPLIT8  = 2'b11
  } tmode_e;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cyc_en,
  input  logic [N-1:0] pin,
  output logic [N-1:0] tick
);
  logic [N-1:0] smp;

  always_ff @(posedge clk) begin
    if (rst)         smp <= '0;
    else if (cyc_en) smp <= pin;
  end

  assign tick = {N{cyc_en}} & smp & ~pin;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R9
    tick_rate_chk: assert property (@(posedge clk) disable iff (rst)
      tick[g] |=> !tick[g]);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE      = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  tmode_e       mode,
  input  logic         tick_lo,
  input  logic         tick_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf,
  output logic         ovf_hi
);
  localparam logic [2*W-1:0] ONE2 = (2*W)'(1);

  logic [W-1:0] lo_n, hi_n;
  logic         blk;

  assign blk = wr_lo | wr_hi;

  always_comb begin
    lo_n   = lo;
    hi_n   = hi;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    case (mode)
      CNT13: if (tick_lo && !blk) begin
        lo_n[PRE-1:0] = lo[PRE-1:0] + 1'b1;
        if (&lo[PRE-1:0]) begin
          hi_n = hi + 1'b1;
          ovf  = &hi;
        end
      end
      CNT16: if (tick_lo && !blk) begin
        {hi_n, lo_n} = {hi, lo} + ONE2;
        ovf          = (&lo) & (&hi);
      end
      RELOAD8: if (tick_lo && !blk) begin
        if (&lo) begin
          lo_n = hi;
          ovf  = 1'b1;
        end else begin
          lo_n = lo + 1'b1;
        end
      end
      default: if (SPLIT_OK) begin
        if (tick_lo && !wr_lo) begin
          lo_n = lo + 1'b1;
          ovf  = &lo;
        end
        if (tick_hi && !wr_hi) begin
          hi_n   = hi + 1'b1;
          ovf_hi = &hi;
        end
      end
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  // R11
  wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo == $past(wr_data));
  // R4
  cnt16_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CNT16 && tick_lo && !blk) |=> {hi, lo} == $past({hi, lo}) + ONE2);
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == RELOAD8 && tick_lo && !blk && (&lo)) |=> lo == $past(hi));
  // R3
  pre_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CNT13 && !blk) |=> $stable(lo[W-1:PRE]));

  if (!SPLIT_OK) begin : g_hold
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == SPLIT8 && !blk) |=> ($stable(lo) && $stable(hi)));
  end
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int PRE = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cyc_en,
  input  logic [1:0]   gate_pin,
  input  logic [1:0]   cnt_pin,
  input  logic [1:0]   ack,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [1:0]   ovf_flag,
  output logic         ch1_pulse
);
  localparam int NCH = 2;

  logic [7:0]     mode_q;
  logic [NCH-1:0] run_q, flag_q, flag_n, set_v, ext_tick;
  logic           wr_mode, wr_ctrl, wr_lo0, wr_hi0, wr_lo1, wr_hi1;
  logic           split, tick0, tick0_hi, en1, tick1;
  logic [W-1:0]   c0_lo, c0_hi, c1_lo, c1_hi;
  logic           c0_ovf, c0_ovf_hi, c1_ovf, c1_ovf_hi;
  tmode_e         m0, m1;

  assign wr_mode = wr_en && wr_addr == A_MODE;
  assign wr_ctrl = wr_en && wr_addr == A_CTRL;
  assign wr_lo0  = wr_en && wr_addr == A_LO0;
  assign wr_hi0  = wr_en && wr_addr == A_HI0;
  assign wr_lo1  = wr_en && wr_addr == A_LO1;
  assign wr_hi1  = wr_en && wr_addr == A_HI1;

  assign m0    = tmode_e'(mode_q[1:0]);
  assign m1    = tmode_e'(mode_q[5:4]);
  assign split = (m0 == SPLIT8);

  tmr_edge #(.N(NCH)) u_edge (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .pin(cnt_pin), .tick(ext_tick)
  );

  assign tick0    = run_q[0] & (~mode_q[3] | gate_pin[0]) &
                    (mode_q[2] ? ext_tick[0] : cyc_en);
  assign tick0_hi = split & run_q[1] & cyc_en;
  assign en1      = split | (run_q[1] & (~mode_q[7] | gate_pin[1]));
  assign tick1    = en1 & (mode_q[6] ? ext_tick[1] : cyc_en);

  tmr_chan #(.W(W), .PRE(PRE), .SPLIT_OK(1'b1)) u_ch0 (
    .clk(clk), .rst(rst), .mode(m0), .tick_lo(tick0), .tick_hi(tick0_hi),
    .wr_lo(wr_lo0), .wr_hi(wr_hi0), .wr_data(wr_data),
    .lo(c0_lo), .hi(c0_hi), .ovf(c0_ovf), .ovf_hi(c0_ovf_hi)
  );

  tmr_chan #(.W(W), .PRE(PRE), .SPLIT_OK(1'b0)) u_ch1 (
    .clk(clk), .rst(rst), .mode(m1), .tick_lo(tick1), .tick_hi(1'b0),
    .wr_lo(wr_lo1), .wr_hi(wr_hi1), .wr_data(wr_data),
    .lo(c1_lo), .hi(c1_hi), .ovf(c1_ovf), .ovf_hi(c1_ovf_hi)
  );

  assign set_v[0] = c0_ovf;
  assign set_v[1] = split ? c0_ovf_hi : (c1_ovf | c1_ovf_hi);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      flag_n[i] = flag_q[i];
      if (wr_ctrl)  flag_n[i] = wr_data[NCH+i];
      if (ack[i])   flag_n[i] = 1'b0;
      if (set_v[i]) flag_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      run_q     <= '0;
      flag_q    <= '0;
      ch1_pulse <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_mode) mode_q <= wr_data[7:0];
      if (wr_ctrl) run_q  <= wr_data[NCH-1:0];
      flag_q    <= flag_n;
      ch1_pulse <= c1_ovf | c1_ovf_hi;
      case (rd_addr)
        A_MODE:  rd_data <= W'(mode_q);
        A_CTRL:  rd_data <= W'({flag_q, run_q});
        A_LO0:   rd_data <= c0_lo;
        A_HI0:   rd_data <= c0_hi;
        A_LO1:   rd_data <= c1_lo;
        A_HI1:   rd_data <= c1_hi;
        default: rd_data <= '0;
      endcase
    end
  end

  assign ovf_flag = flag_q;

  // R10
  ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack[0] && !c0_ovf) |=> !ovf_flag[0]);
  // R10
  hw_set_chk: assert property (@(posedge clk) disable iff (rst)
    c0_ovf |=> ovf_flag[0]);
  // R6
  split_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (split && !c0_ovf_hi && !wr_ctrl && !ack[1]) |=> $stable(ovf_flag[1]));
  // R8
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[3] && !gate_pin[0] && !wr_lo0) |=> $stable(c0_lo));
endmodule

// File: tb/sim_dual_tmr.sv
module sim_dual_tmr;
  import tmr_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] cnt_pin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic [1:0] ovf_flag;
  logic       ch1_pulse;

  int checks = 0;
  int fails = 0;
  int pcnt = 0;
  int p0;
  bit done = 1'b0;
  logic [7:0] v;

  always #2 clk = ~clk;

  dual_tmr u0 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .gate_pin(gate_pin),
    .cnt_pin(cnt_pin), .ack(ack), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_flag(ovf_flag), .ch1_pulse(ch1_pulse)
  );

  always @(negedge clk) if (!rst && ch1_pulse) pcnt <= pcnt + 1;

  // {mode, lo, hi, steps, exp lo, exp hi, exp flag0}
  localparam logic [55:0] TBL [7] = '{
    {8'h01, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 8'h01},
    {8'h01, 8'h10, 8'h20, 8'd5, 8'h15, 8'h20, 8'h00},
    {8'h00, 8'hFE, 8'h05, 8'd3, 8'hE1, 8'h06, 8'h00},
    {8'h00, 8'h1F, 8'hFF, 8'd1, 8'h00, 8'h00, 8'h01},
    {8'h02, 8'hFD, 8'hC8, 8'd4, 8'hC9, 8'hC8, 8'h01},
    {8'h02, 8'h00, 8'h80, 8'd2, 8'h02, 8'h80, 8'h00},
    {8'h03, 8'hFF, 8'h33, 8'd2, 8'h01, 8'h33, 8'h01}
  };
  localparam string TAGS [7] = '{"R4", "R4", "R3", "R3", "R5", "R5", "R6"};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic steps(input int n);
    @(negedge clk);
    cyc_en = 1'b1;
    repeat (n) @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic mc(input logic p);
    @(negedge clk);
    cnt_pin[0] = p; cyc_en = 1'b1;
    @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", int'(v), 0);
    end
    chk("R1 flags", int'(ovf_flag), 0);
    chk("R1 pulse", int'(ch1_pulse), 0);

    wr(A_MODE, 8'hA5);
    rd(A_MODE, v);
    chk("R2 mode readback", int'(v), 8'hA5);

    for (int i = 0; i < 7; i++) begin
      wr(A_CTRL, 8'h00);
      wr(A_MODE, TBL[i][55:48]);
      wr(A_LO0, TBL[i][47:40]);
      wr(A_HI0, TBL[i][39:32]);
      wr(A_CTRL, 8'h01);
      steps(int'(TBL[i][31:24]));
      rd(A_LO0, v);
      chk({TAGS[i], " low"}, int'(v), int'(TBL[i][23:16]));
      rd(A_HI0, v);
      chk({TAGS[i], " high"}, int'(v), int'(TBL[i][15:8]));
      rd(A_CTRL, v);
      chk({TAGS[i], " flag0"}, int'(v[2]), int'(TBL[i][0]));
      chk({TAGS[i], " flag out"}, int'(ovf_flag[0]), int'(TBL[i][0]));
    end

    // R8 gating
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h09); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
    wr(A_CTRL, 8'h01);
    gate_pin[0] = 1'b0;
    steps(4);
    rd(A_LO0, v);
    chk("R8 gate low holds", int'(v), 0);
    gate_pin[0] = 1'b1;
    steps(4);
    rd(A_LO0, v);
    chk("R8 gate high counts", int'(v), 4);
    gate_pin[0] = 1'b0;

    // R9 external falling edges
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h05); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
    wr(A_CTRL, 8'h01);
    mc(1'b1); mc(1'b0); mc(1'b0);
    @(negedge clk); cnt_pin[0] = 1'b1;
    @(negedge clk); cnt_pin[0] = 1'b0;
    mc(1'b0);
    mc(1'b1); mc(1'b0);
    rd(A_LO0, v);
    chk("R9 edge count", int'(v), 2);

    // R11 write wins over step
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h01); wr(A_LO0, 8'h10); wr(A_HI0, 8'h00);
    wr(A_CTRL, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_LO0; wr_data = 8'h40; cyc_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cyc_en = 1'b0;
    rd(A_LO0, v);
    chk("R11 write priority low", int'(v), 8'h40);
    rd(A_HI0, v);
    chk("R11 write priority high", int'(v), 8'h00);

    // R10 ack and software clear
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
    steps(1);
    chk("R10 flag set", int'(ovf_flag[0]), 1);
    @(negedge clk); ack[0] = 1'b1;
    @(negedge clk); ack[0] = 1'b0;
    chk("R10 ack clears", int'(ovf_flag[0]), 0);
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
    steps(1);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, v);
    chk("R10 write clears", int'(v), 8'h01);

    // R6 / R12 split mode
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h13);
    wr(A_LO1, 8'hFE); wr(A_HI1, 8'hFF); wr(A_HI0, 8'hFE); wr(A_LO0, 8'h00);
    wr(A_CTRL, 8'h02);
    p0 = pcnt;
    steps(3);
    rd(A_HI0, v);
    chk("R6 split high", int'(v), 8'h01);
    rd(A_LO0, v);
    chk("R6 split low idle", int'(v), 8'h00);
    chk("R6 flag1 from high half", int'(ovf_flag[1]), 1);
    rd(A_LO1, v);
    chk("R6 ch1 runs", int'(v), 8'h01);
    chk("R12 one pulse", pcnt - p0, 1);
    wr(A_CTRL, 8'h00);
    wr(A_LO1, 8'hFF); wr(A_HI1, 8'hFF);
    p0 = pcnt;
    steps(2);
    rd(A_LO1, v);
    chk("R6 ch1 unstoppable", int'(v), 8'h01);
    chk("R6 ch1 no flag1", int'(ovf_flag[1]), 0);
    rd(A_HI0, v);
    chk("R6 high half stopped", int'(v), 8'h01);
    chk("R12 pulse in split", pcnt - p0, 1);

    // R7 channel 1 mode 11 holds
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h31); wr(A_LO1, 8'h05); wr(A_HI1, 8'h00);
    wr(A_CTRL, 8'h02);
    steps(3);
    rd(A_LO1, v);
    chk("R7 ch1 halted", int'(v), 8'h05);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule